// File: doc/BRIEF.md
# Transmit Frame Queue Manager

This block sits on the transmit path between a host that writes frames and a MAC that consumes them. The host pushes 16-bit words into a 4 KB circular packet memory. Each frame is laid down as a two-word header followed by its payload. The first header word is a control word. The second header word is the payload length in bytes. Several frames may wait in memory at once. A drain engine parses each header in turn and streams the payload to the MAC side as 16-bit words, using valid/ready handshaking.

The drain engine publishes status for the frame it is currently streaming: a busy flag, an error flag and the frame's 6-bit identifier. It raises a level interrupt when a frame that requested one has gone out completely. A frame with an impossible length is dropped, and only its header is removed from memory. A host write that finds the memory full is refused and recorded in a sticky overflow flag. The host clears both the interrupt and the overflow flag by writing ones to `hostClr`.

Top module: `txq_top`

## Requirements
- R1: Word 0 of a frame is the control word and word 1 is the byte count. In the control word, bit 15 requests a completion interrupt and bits 5..0 carry the frame ID. Bits 14..6 have no effect. Payload words follow from word 2.
- R2: Payload bytes leave in write order, with the earlier byte in bits 7..0 of each word. `macLast` is high only on the final payload word. `macBe` is 2'b11 on every word except the final word of an odd-length frame, where it is 2'b01.
- R3: After a frame, the read position advances by the byte count rounded up to whole words. The next header is therefore read from the word directly after the padded payload.
- R4: Several frames written back to back without any draining are later delivered complete and in write order.
- R5: While a frame streams, `statBusy` is 1 and `statId` holds that frame's ID, even when later frames are already queued. `statBusy` returns to 0 once the queue is empty.
- R6: After the final word of a frame whose control bit 15 is set is accepted, `txIntr` is 1 from the next cycle on. It stays 1 until a cycle with `hostClr[0]`=1. A frame with bit 15 clear leaves `txIntr` at 0.
- R7: A byte count of 0 or greater than 1916 makes the frame be skipped. Only its two header words are consumed, no payload word is presented, no interrupt is raised, and `statErr`=1 with `statId` set to its ID. A count of exactly 1916 is accepted.
- R8: A host write that arrives while 2048 words are held is refused and leaves memory and pointers untouched. The refusal sets `ovfErr`, which stays 1 until `hostClr[1]`=1.
- R9: While `macValid`=1 and `macReady`=0, `macData`, `macLast`, `macBe` and `macValid` hold steady.
- R10: After reset, `macValid`, `statBusy`, `statErr`, `txIntr` and `ovfErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrValid | input | 1 | Host writes one word this cycle |
| hostWrData | input | 16 | Host write word |
| hostClr | input | 2 | Write-one-to-clear: bit 0 interrupt, bit 1 overflow flag |
| macValid | output | 1 | Payload word available |
| macReady | input | 1 | MAC accepts the word |
| macData | output | 16 | Payload word, earlier byte in bits 7..0 |
| macLast | output | 1 | Final word of the frame |
| macBe | output | 2 | Byte enables of the current word |
| statBusy | output | 1 | A frame is streaming |
| statErr | output | 1 | Last parsed header was skipped for a bad length |
| statId | output | 6 | ID of the frame last parsed |
| txIntr | output | 1 | Completion interrupt level |
| ovfErr | output | 1 | Sticky write-refused flag |

## Verification
Byte counts from 1 to 40 are swept. This separates even lengths from odd lengths in the byte enables, and shows whether the word-rounding advance lands on the next header. The sweep alternates between a MAC that is always ready and one that stalls every third cycle, so a lost or repeated word shows up. Three frames queued before any draining distinguish status for the current frame from status for the last frame written. Lengths of 0, 1916 and 1917 bracket the acceptance window. Filling all 2048 words and then writing once more, before draining, shows whether a refused write overwrites the oldest unread word.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // strobes from the drain control to the memory datapath
  typedef struct packed {
    logic popHdr;   // consume two header words
    logic popData;  // consume one payload word
  } txq_strobe_t;
endpackage

// File: rtl/txq_datapath.sv
module txq_datapath
  import txq_pkg::*;
#(
  parameter int WORDS = 2048,
  parameter int AW    = 11,
  parameter int CW    = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic [15:0]   wrData,
  input  txq_strobe_t   strobe,
  output logic          wrReject,
  output logic [CW-1:0] fill,
  output logic [15:0]   rdWord0,
  output logic [15:0]   rdWord1
);
  logic [15:0]   mem [WORDS];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic          wrAccept;
  logic [1:0]    popCount;

  assign wrAccept = wrValid && (fill != CW'(WORDS));
  assign wrReject = wrValid && !wrAccept;
  assign popCount = strobe.popHdr ? 2'd2 : (strobe.popData ? 2'd1 : 2'd0);

  always_ff @(posedge clk) begin
    if (wrAccept) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (wrAccept) wrPtr <= wrPtr + AW'(1);
      rdPtr <= rdPtr + AW'(popCount);
      fill  <= fill + CW'(wrAccept) - CW'(popCount);
    end
  end

  assign rdWord0 = mem[rdPtr];
  assign rdWord1 = mem[rdPtr + AW'(1)];
endmodule

// File: rtl/txq_control.sv
module txq_control
  import txq_pkg::*;
#(
  parameter int MAX_LEN = 1916,
  parameter int CW      = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] fill,
  input  logic [15:0]   rdWord0,
  input  logic [15:0]   rdWord1,
  input  logic          wrReject,
  input  logic [1:0]    hostClr,
  input  logic          macReady,
  output txq_strobe_t   strobe,
  output logic          macValid,
  output logic [15:0]   macData,
  output logic          macLast,
  output logic [1:0]    macBe,
  output logic          statBusy,
  output logic          statErr,
  output logic [5:0]    statId,
  output logic          txIntr,
  output logic          ovfErr
);
  localparam int MAXW = (MAX_LEN + 1) / 2;
  localparam int RW   = $clog2(MAXW + 1);

  typedef enum logic {S_IDLE, S_SEND} state_t;

  state_t        state;
  logic [RW-1:0] remWords;
  logic          oddLen;
  logic          wantIntr;
  logic          hdrAvail;
  logic          hdrOk;
  logic [16:0]   roundWords;
  logic          fire;

  assign hdrAvail   = (state == S_IDLE) && (fill >= CW'(2));
  assign hdrOk      = (rdWord1 != 16'd0) && (rdWord1 <= 16'(MAX_LEN));
  assign roundWords = ({1'b0, rdWord1} + 17'd1) >> 1;

  assign macValid = (state == S_SEND) && (fill != '0);
  assign macData  = rdWord0;
  assign macLast  = (remWords == RW'(1));
  assign macBe    = (macLast && oddLen) ? 2'b01 : 2'b11;
  assign fire     = macValid && macReady;
  assign statBusy = (state == S_SEND);

  always_comb begin
    strobe         = '0;
    strobe.popHdr  = hdrAvail;
    strobe.popData = fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      remWords <= '0;
      oddLen   <= 1'b0;
      wantIntr <= 1'b0;
      statErr  <= 1'b0;
      statId   <= '0;
      txIntr   <= 1'b0;
      ovfErr   <= 1'b0;
    end else begin
      if (hdrAvail) begin
        statId  <= rdWord0[5:0];
        statErr <= !hdrOk;
        if (hdrOk) begin
          state    <= S_SEND;
          remWords <= RW'(roundWords);
          oddLen   <= rdWord1[0];
          wantIntr <= rdWord0[15];
        end
      end
      if (fire) begin
        remWords <= remWords - RW'(1);
        if (macLast) state <= S_IDLE;
      end
      if (fire && macLast && wantIntr) txIntr <= 1'b1;
      else if (hostClr[0])             txIntr <= 1'b0;
      if (wrReject)        ovfErr <= 1'b1;
      else if (hostClr[1]) ovfErr <= 1'b0;
    end
  end
endmodule

// File: rtl/txq_top.sv
module txq_top
  import txq_pkg::*;
#(
  parameter int DEPTH_BYTES = 4096,
  parameter int MAX_LEN     = 1916
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrValid,
  input  logic [15:0] hostWrData,
  input  logic [1:0]  hostClr,
  output logic        macValid,
  input  logic        macReady,
  output logic [15:0] macData,
  output logic        macLast,
  output logic [1:0]  macBe,
  output logic        statBusy,
  output logic        statErr,
  output logic [5:0]  statId,
  output logic        txIntr,
  output logic        ovfErr
);
  localparam int WORDS = DEPTH_BYTES / 2;
  localparam int AW    = $clog2(WORDS);
  localparam int CW    = AW + 1;

  txq_strobe_t   strobe;
  logic          wrReject;
  logic [CW-1:0] fill;
  logic [15:0]   rdWord0;
  logic [15:0]   rdWord1;

  txq_datapath #(.WORDS(WORDS), .AW(AW), .CW(CW)) i_dp (
    .clk(clk), .rstN(rstN), .wrValid(hostWrValid), .wrData(hostWrData),
    .strobe(strobe), .wrReject(wrReject), .fill(fill),
    .rdWord0(rdWord0), .rdWord1(rdWord1)
  );

  txq_control #(.MAX_LEN(MAX_LEN), .CW(CW)) i_ctl (
    .clk(clk), .rstN(rstN), .fill(fill), .rdWord0(rdWord0), .rdWord1(rdWord1),
    .wrReject(wrReject), .hostClr(hostClr), .macReady(macReady),
    .strobe(strobe), .macValid(macValid), .macData(macData), .macLast(macLast),
    .macBe(macBe), .statBusy(statBusy), .statErr(statErr), .statId(statId),
    .txIntr(txIntr), .ovfErr(ovfErr)
  );
endmodule

// File: rtl/txq_checker.sv
module txq_checker #(
  parameter int WORDS = 2048,
  parameter int CW    = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic          hostWrValid,
  input logic          macValid,
  input logic          macReady,
  input logic [15:0]   macData,
  input logic          macLast,
  input logic [1:0]    macBe,
  input logic          statErr,
  input logic          txIntr,
  input logic          ovfErr,
  input logic [CW-1:0] fill
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (macValid && !macReady) |=> (macValid && $stable(macData) && $stable(macLast) && $stable(macBe)));

  assert_be_R2: assert property (@(posedge clk) disable iff (!rstN)
    (macValid && !macLast) |-> (macBe == 2'b11));

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CW'(WORDS));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrValid && fill == CW'(WORDS)) |=> ovfErr);

  assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfErr) |-> $past(hostWrValid));

  assert_intr_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txIntr) |-> $past(macValid && macReady && macLast));

  assert_skip_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    statErr |-> !macValid);
endmodule

bind txq_top txq_checker #(.WORDS(WORDS), .CW(CW)) i_chk (
  .clk(clk), .rstN(rstN), .hostWrValid(hostWrValid), .macValid(macValid),
  .macReady(macReady), .macData(macData), .macLast(macLast), .macBe(macBe),
  .statErr(statErr), .txIntr(txIntr), .ovfErr(ovfErr), .fill(fill)
);

// File: tb/test_txq_top.sv
`timescale 1ns/1ps
module test_txq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrValid = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [1:0]  hostClr = '0;
  logic        macReady = 1'b0;
  logic        macValid, macLast, statBusy, statErr, txIntr, ovfErr;
  logic [15:0] macData;
  logic [1:0]  macBe;
  logic [5:0]  statId;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  txq_top i_txq_top (
    .clk(clk), .rstN(rstN), .hostWrValid(hostWrValid), .hostWrData(hostWrData),
    .hostClr(hostClr), .macValid(macValid), .macReady(macReady), .macData(macData),
    .macLast(macLast), .macBe(macBe), .statBusy(statBusy), .statErr(statErr),
    .statId(statId), .txIntr(txIntr), .ovfErr(ovfErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] patWord(input int n, input int j);
    return {8'(n * 7 + 2 * j + 1), 8'(n * 7 + 2 * j)};
  endfunction

  task automatic putWord(input logic [15:0] w);
    @(negedge clk);
    hostWrValid = 1'b1;
    hostWrData  = w;
  endtask

  task automatic hostIdle();
    @(negedge clk);
    hostWrValid = 1'b0;
  endtask

  // control word with junk in the reserved bits (R1)
  task automatic writeFrame(input int n, input int count, input int id, input bit ioc, input int nWords);
    putWord({ioc, 9'h15A, 6'(id)});
    putWord(16'(count));
    for (int j = 0; j < nWords; j++) putWord(patWord(n, j));
    hostIdle();
  endtask

  task automatic drainFrame(input int n, input int count, input int mode);
    int words = (count + 1) / 2;
    int j = 0;
    int k = 0;
    while (j < words && k < 20 * words + 100) begin
      @(negedge clk);
      macReady = (mode == 0) || (k % 3 != 1);
      k++;
      if (macValid && macReady) begin
        check(macData == patWord(n, j), "R2 data", macData, patWord(n, j));
        check(macLast == (j == words - 1), "R2 last", macLast, (j == words - 1));
        check(macBe == ((j == words - 1 && count % 2 == 1) ? 2'b01 : 2'b11), "R2 be",
              macBe, (j == words - 1 && count % 2 == 1) ? 1 : 3);
        j++;
      end
    end
    check(j == words, "R3 word count", j, words);
    @(negedge clk);
    macReady = 1'b0;
  endtask

  task automatic clearIntr();
    @(negedge clk); hostClr = 2'b01;
    @(negedge clk); hostClr = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!macValid, "R10 macValid", macValid, 0);
    check(!statBusy, "R10 statBusy", statBusy, 0);
    check(!statErr,  "R10 statErr", statErr, 0);
    check(!txIntr,   "R10 txIntr", txIntr, 0);
    check(!ovfErr,   "R10 ovfErr", ovfErr, 0);

    // R1 R2 R3 R5 R6: length sweep with two ready patterns
    for (int n = 1; n <= 40; n++) begin
      int id = (n * 5 + 3) % 64;
      bit ioc = n[0];
      writeFrame(n, n, id, ioc, (n + 1) / 2);
      repeat (2) @(negedge clk);
      check(statBusy, "R5 busy", statBusy, 1);
      check(statId == 6'(id), "R1 R5 id", statId, id);
      check(!statErr, "R7 no err", statErr, 0);
      drainFrame(n, n, n % 2);
      check(txIntr == ioc, "R6 intr", txIntr, ioc);
      check(!statBusy, "R5 idle", statBusy, 0);
      clearIntr();
      check(!txIntr, "R6 clear", txIntr, 0);
    end

    // R4 R5: three frames queued before draining
    writeFrame(50, 5, 10, 1'b0, 3);
    writeFrame(51, 8, 11, 1'b0, 4);
    writeFrame(52, 3, 12, 1'b1, 2);
    repeat (2) @(negedge clk);
    check(statId == 6'd10, "R5 current id", statId, 10);
    drainFrame(50, 5, 1);
    check(!txIntr, "R6 no intr", txIntr, 0);
    repeat (2) @(negedge clk);
    check(statId == 6'd11, "R4 second id", statId, 11);
    drainFrame(51, 8, 0);
    repeat (2) @(negedge clk);
    check(statId == 6'd12, "R4 third id", statId, 12);
    drainFrame(52, 3, 1);
    check(txIntr, "R6 intr third", txIntr, 1);
    clearIntr();

    // R7 bad lengths skipped, header only
    writeFrame(60, 0, 33, 1'b1, 0);
    repeat (3) @(negedge clk);
    check(statErr, "R7 zero err", statErr, 1);
    check(statId == 6'd33, "R7 zero id", statId, 33);
    check(!macValid, "R7 zero quiet", macValid, 0);
    check(!statBusy, "R7 zero busy", statBusy, 0);
    writeFrame(61, 1917, 34, 1'b1, 0);
    repeat (3) @(negedge clk);
    check(statErr, "R7 long err", statErr, 1);
    check(statId == 6'd34, "R7 long id", statId, 34);
    check(!macValid, "R7 long quiet", macValid, 0);
    check(!txIntr, "R7 no intr", txIntr, 0);
    writeFrame(62, 1916, 35, 1'b1, 958);
    repeat (2) @(negedge clk);
    check(!statErr, "R7 max ok", statErr, 0);
    check(statId == 6'd35, "R7 max id", statId, 35);
    drainFrame(62, 1916, 1);
    check(txIntr, "R6 R7 max intr", txIntr, 1);
    clearIntr();

    // R8 overflow: header consumed, then 2048 words fill memory, one more refused
    check(!ovfErr, "R8 clean", ovfErr, 0);
    writeFrame(70, 1916, 7, 1'b0, 2048);
    check(!ovfErr, "R8 full no err", ovfErr, 0);
    putWord(16'hDEAD);
    hostIdle();
    @(negedge clk);
    check(ovfErr, "R8 refused", ovfErr, 1);
    @(negedge clk);
    check(macValid && macData == patWord(70, 0), "R8 R9 oldest intact", macData, patWord(70, 0));
    drainFrame(70, 1916, 0);
    check(ovfErr, "R8 sticky", ovfErr, 1);
    @(negedge clk); hostClr = 2'b10;
    @(negedge clk); hostClr = 2'b00;
    check(!ovfErr, "R8 clear", ovfErr, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule